// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches an eight-pin input port and turns pin activity into one combined interrupt line. Each pin has its own sensing choice: level sensing, or edge sensing on a single edge or on both edges. A per-pin event bit serves two purposes. It selects the active polarity in single-edge mode, and it selects the active level in level mode. Detected events are held in a sticky raw status register. Software clears that register by writing ones to a clear address. A mask register selects which status bits drive the interrupt line.

The pin levels arrive already synchronized to the block clock, together with a per-pin qualifier that marks the pin as an input. Edges are found by comparing each pin with its value one cycle earlier. Only pins marked as inputs can raise status. Configuration and status sit behind a simple single-cycle register port. Writes complete on the clock edge, and reads return data combinationally from the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset, the sense, both-edges, event, mask and raw status registers all read 0, and `irq_out` is low.
- R2: The sense register is at offset 0x404, both-edges at 0x408, event at 0x40C and mask at 0x410. Bit i of each controls pin i. A write takes effect on the clock edge, and the written value reads back at the same offset.
- R3: For a pin with sense bit 0 and both-edges bit 1, any change of its level between two consecutive clock edges sets its raw status bit at the second edge.
- R4: For a pin with sense bit 0 and both-edges bit 0, a change sets its raw status bit only when the new level equals its event bit: event 1 catches rising edges, event 0 catches falling edges. The opposite edge leaves the bit unchanged.
- R5: For a pin with sense bit 1, the raw status bit is set on every clock edge at which the pin level equals its event bit. A clear therefore does not remove it while that level persists.
- R6: A write to offset 0x41C clears each raw status bit whose written data bit is 1. Bits written as 0 keep their value.
- R7: When a pin's set condition and a clear of the same bit occur in the same cycle, the bit ends up set.
- R8: Raw status reads at offset 0x414. Masked status reads at offset 0x418 and equals raw status AND mask.
- R9: `irq_out` is high exactly when at least one masked status bit is 1. With mask 0 it stays low whatever the raw status.
- R10: A pin whose `pin_is_input` bit is 0 never sets its status bit, in any sensing mode.
- R11: Reads of unmapped offsets return 0. Writes to the status read offsets 0x414 and 0x418 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe for one cycle |
| bus_addr | input | 12 | Register byte offset for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_level | input | 8 | Synchronized pin levels |
| pin_is_input | input | 8 | Per-pin input qualifier, 1 = input |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The assertions run on every cycle and cover the following. A newly set status bit must come from a pin marked as input. In edge mode, a new status bit must be backed by a real change against the stored previous level. A set must beat a same-cycle clear. A zero mask must keep the interrupt low, and mask writes must land. Only the bench's scenarios can show that the polarity decode is correct across mixed per-pin configurations, that level-mode bits re-assert after a clear, that the masked read and the interrupt line follow partial masks, and that unmapped reads and writes to the status offsets are inert.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SENSE,
        SEL_BOTH,
        SEL_EVENT,
        SEL_MASK,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_SENSE:  sel = SEL_SENSE;
            OFS_BOTH:   sel = SEL_BOTH;
            OFS_EVENT:  sel = SEL_EVENT;
            OFS_MASK:   sel = SEL_MASK;
            OFS_RAW:    sel = SEL_RAW;
            OFS_MASKED: sel = SEL_MASKED;
            OFS_CLEAR:  sel = SEL_CLEAR;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] raw_status,
    output logic [NUM_PINS-1:0] sense_q,
    output logic [NUM_PINS-1:0] both_q,
    output logic [NUM_PINS-1:0] event_q,
    output logic [NUM_PINS-1:0] mask_q,
    output logic [NUM_PINS-1:0] clr_vec
);

    reg_sel_e sel;

    assign sel = decode_ofs(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            both_q  <= '0;
            event_q <= '0;
            mask_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_SENSE: sense_q <= bus_wdata;
                SEL_BOTH:  both_q  <= bus_wdata;
                SEL_EVENT: event_q <= bus_wdata;
                SEL_MASK:  mask_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign clr_vec = (bus_wr && sel == SEL_CLEAR) ? bus_wdata : '0;

    always_comb begin
        case (sel)
            SEL_SENSE:  bus_rdata = sense_q;
            SEL_BOTH:   bus_rdata = both_q;
            SEL_EVENT:  bus_rdata = event_q;
            SEL_MASK:   bus_rdata = mask_q;
            SEL_RAW:    bus_rdata = raw_status;
            SEL_MASKED: bus_rdata = raw_status & mask_q;
            default:    bus_rdata = '0;
        endcase
    end

    AST_MASK_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_MASK) |=> (mask_q == $past(bus_wdata))); // R2

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] pin_is_input,
    input  logic [NUM_PINS-1:0] sense_q,
    input  logic [NUM_PINS-1:0] both_q,
    input  logic [NUM_PINS-1:0] event_q,
    output logic [NUM_PINS-1:0] prev_q,
    output logic [NUM_PINS-1:0] set_vec
);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_level;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic changed;
        logic at_event;
        logic edge_hit;

        assign changed  = pin_level[i] ^ prev_q[i];
        assign at_event = ~(pin_level[i] ^ event_q[i]);
        assign edge_hit = changed & (both_q[i] | at_event);
        assign set_vec[i] = pin_is_input[i] & (sense_q[i] ? at_event : edge_hit);
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] set_vec,
    input  logic [NUM_PINS-1:0] clr_vec,
    input  logic [NUM_PINS-1:0] mask_q,
    output logic [NUM_PINS-1:0] raw_q,
    output logic                irq_out
);

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= (raw_q & ~clr_vec) | set_vec;
    end

    assign irq_out = |(raw_q & mask_q);

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & clr_vec)) |=> ((raw_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec))); // R7

    AST_UNCLEARED_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(raw_q) & ~$past(clr_vec)) & ~raw_q) == '0)); // R6

    AST_MASKED_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_out); // R9

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] pin_is_input,
    output logic                irq_out
);

    logic [NUM_PINS-1:0] sense_q, both_q, event_q, mask_q;
    logic [NUM_PINS-1:0] clr_vec, set_vec, prev_q, raw_q;

    gpio_irq_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .raw_status (raw_q),
        .sense_q    (sense_q),
        .both_q     (both_q),
        .event_q    (event_q),
        .mask_q     (mask_q),
        .clr_vec    (clr_vec)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) i_detect (
        .clk          (clk),
        .rst          (rst),
        .pin_level    (pin_level),
        .pin_is_input (pin_is_input),
        .sense_q      (sense_q),
        .both_q       (both_q),
        .event_q      (event_q),
        .prev_q       (prev_q),
        .set_vec      (set_vec)
    );

    gpio_irq_status #(.NUM_PINS(NUM_PINS)) i_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mask_q  (mask_q),
        .raw_q   (raw_q),
        .irq_out (irq_out)
    );

    AST_ONLY_INPUTS_RAISE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(pin_is_input)) == '0)); // R10

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(sense_q)
                   & ~($past(pin_level) ^ $past(prev_q))) == '0)); // R3

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    // {sense, both, event, mask, is_input, level_before, level_after, raw_expected}
    localparam logic [63:0] VEC [NV] = '{
        64'h00_FF_00_FF_FF_00_0F_0F,  // R3 any edge
        64'h00_00_FF_FF_FF_0F_F0_F0,  // R4 rising only
        64'h00_00_00_F0_FF_0F_F0_0F,  // R4 falling only
        64'h00_00_AA_FF_FF_00_FF_AA,  // R4 mixed polarity
        64'h00_FF_00_FF_0F_00_FF_0F,  // R10 output pins ignored
        64'hFF_00_0F_0F_FF_00_00_F0,  // R5 level, masked off
        64'hF0_0F_00_3C_FF_55_AA_FF,  // R5 mixed level and edge
        64'h00_FF_00_00_FF_00_01_01   // R9 mask zero
    };

    logic        clk = 0;
    logic        rst;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_level;
    logic [7:0]  pin_is_input;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pin_level    (pin_level),
        .pin_is_input (pin_is_input),
        .irq_out      (irq_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0; bus_addr = 12'h000; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 12'h000;
    endtask

    function automatic string vtag(input int k);
        case (k)
            0: return "R3 vector";
            1, 2, 3: return "R4 vector";
            4: return "R10 vector";
            5, 6: return "R5 vector";
            default: return "R9 vector";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        pin_level = 0; pin_is_input = 8'hFF;
        repeat (3) tick();
        rst = 0;
        tick();

        // R1 reset state
        rd(12'h404, v); check("R1 sense", v, 8'h00);
        rd(12'h408, v); check("R1 both", v, 8'h00);
        rd(12'h40C, v); check("R1 event", v, 8'h00);
        rd(12'h410, v); check("R1 mask", v, 8'h00);
        rd(12'h414, v); check("R1 raw", v, 8'h00);
        check("R1 irq", {7'b0, irq_out}, 8'h00);

        // R2 readback
        wr(12'h404, 8'h00); wr(12'h408, 8'hC3); wr(12'h40C, 8'h5A); wr(12'h410, 8'h81);
        rd(12'h408, v); check("R2 both", v, 8'hC3);
        rd(12'h40C, v); check("R2 event", v, 8'h5A);
        rd(12'h410, v); check("R2 mask", v, 8'h81);

        // vector table
        for (int k = 0; k < NV; k++) begin
            logic [63:0] e;
            e = VEC[k];
            pin_is_input = e[31:24];
            pin_level    = e[23:16];
            wr(12'h404, e[63:56]);
            wr(12'h408, e[55:48]);
            wr(12'h40C, e[47:40]);
            wr(12'h410, e[39:32]);
            tick();
            wr(12'h41C, 8'hFF);
            pin_level = e[15:8];
            tick();
            rd(12'h414, v); check({vtag(k), " raw"}, v, e[7:0]);
            rd(12'h418, v); check({"R8 masked ", vtag(k)}, v, e[7:0] & e[39:32]);
            check({"R9 irq ", vtag(k)}, {7'b0, irq_out}, {7'b0, |(e[7:0] & e[39:32])});
        end

        // R6 partial clear (any-edge, all inputs)
        pin_is_input = 8'hFF; pin_level = 8'h00;
        wr(12'h404, 8'h00); wr(12'h408, 8'hFF); wr(12'h410, 8'hFF);
        tick();
        wr(12'h41C, 8'hFF);
        pin_level = 8'h0F;
        tick();
        wr(12'h41C, 8'h05);
        rd(12'h414, v); check("R6 partial clear", v, 8'h0A);

        // R7 set and clear in the same cycle
        wr(12'h41C, 8'hFF);
        rd(12'h414, v); check("R6 full clear", v, 8'h00);
        pin_level = 8'h1F;
        wr(12'h41C, 8'hFF);
        rd(12'h414, v); check("R7 set wins", v, 8'h10);

        // R5 level re-asserts after clear, then drops once level leaves
        wr(12'h41C, 8'hFF);
        wr(12'h404, 8'h01); wr(12'h40C, 8'h01);
        pin_level = 8'h01;
        tick();
        wr(12'h41C, 8'hFF);
        rd(12'h414, v); check("R5 level persists", v & 8'h01, 8'h01);
        pin_level = 8'h00;
        tick();
        wr(12'h41C, 8'hFF);
        rd(12'h414, v); check("R5 level gone", v, 8'h00);

        // R11 status offsets are read-only, unmapped reads zero
        wr(12'h414, 8'hFF);
        wr(12'h418, 8'hFF);
        rd(12'h414, v); check("R11 raw write ignored", v, 8'h00);
        rd(12'h410, v); check("R11 mask untouched", v, 8'hFF);
        rd(12'h500, v); check("R11 unmapped read", v, 8'h00);
        check("R11 irq quiet", {7'b0, irq_out}, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule